// File: doc/BRIEF.md
# PLL Clock Source Switchover and Bus Clock Divider

This block turns two free-running tick streams into the clock enables of a processor subsystem, all inside one fast clock domain. One stream comes from the crystal reference; the other comes from a PLL, which sits outside this block. The block produces three enables: a core enable, a high-speed bus enable derived from the core enable, and a peripheral bus enable derived from the high-speed bus enable. Each enable is a single-cycle pulse. A downstream gate uses each pulse to qualify its register updates, so no clock is ever multiplexed.

After reset the core enable follows the reference ticks. Software must write the PLL configuration register before the block will move to the PLL, and a write of the reset value counts. Every configuration write drops the core back to the reference and starts a countdown, measured in reference ticks. The countdown length comes from a separate lock-time register. When the countdown ends, the core enable starts following the PLL ticks. A two-bit divider register sets whether each bus enable runs at its parent's rate or at half of it.

Top module: `clk_switch_ctrl`

## Requirements
- R1: After reset `on_pll` and `lock_busy` are 0, `pll_cfg` holds `CFG_RESET`, and `core_en` follows the reference ticks.
- R2: With no configuration write, `core_en` keeps following the reference ticks for any length of time.
- R3: A configuration write of any value, the reset value included, sets `lock_busy` to 1 and `on_pll` to 0 on the clock edge that takes the write. From the next cycle `core_en` follows the reference ticks again.
- R4: With a lock length N, the countdown ends on the max(N,1)-th reference tick seen after the write edge. On that edge `lock_busy` falls and `on_pll` rises.
- R5: While `on_pll` is 1, `core_en` equals `pll_tick` delayed by one cycle.
- R6: A configuration write during a running countdown restarts it from the full lock length.
- R7: A lock-length write during a running countdown leaves that countdown unchanged. The new length applies from the next configuration write.
- R8: Divider bit 1 set to 1 makes `hbus_en` pulse on every second core pulse, starting with the first core pulse after the divider write. With the bit at 0, `hbus_en` pulses with every core pulse.
- R9: Divider bit 0 set to 1 makes `pbus_en` pulse on every second `hbus_en` pulse, starting with the first one after the divider write. With the bit at 0, `pbus_en` pulses with every `hbus_en` pulse.
- R10: `core_en` is the selected tick registered once. `hbus_en` is never high without `core_en`, and `pbus_en` is never high without `hbus_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference crystal tick |
| pll_tick | input | 1 | PLL output tick |
| cfg_we | input | 1 | PLL configuration write strobe |
| cfg_wdata | input | CFG_W | PLL configuration value |
| lock_we | input | 1 | Lock-length write strobe |
| lock_wdata | input | LOCK_W | Lock length in reference ticks |
| div_we | input | 1 | Divider write strobe |
| div_wdata | input | 2 | Bit 1 halves the high-speed bus, bit 0 halves the peripheral bus |
| pll_cfg | output | CFG_W | Configuration driven to the PLL |
| core_en | output | 1 | Core clock enable |
| hbus_en | output | 1 | High-speed bus clock enable |
| pbus_en | output | 1 | Peripheral bus clock enable |
| lock_busy | output | 1 | Lock countdown in progress |
| on_pll | output | 1 | Core enable is taken from the PLL |

## Verification
The bench builds the block with a 6-bit lock length that resets to 4 and a 12-bit configuration word. It drives reference ticks every fifth cycle and PLL ticks every second cycle. The short lock length lets the bench count every countdown tick by tick. With this setup the bench can restart a countdown partway through, change the lock length in mid-count, and reach the lengths 0 and 1. Because the two tick rates differ, any cycle taken from the wrong source shows up within a few cycles.

// File: rtl/clkswitch_pkg.sv
package clkswitch_pkg;
  localparam int NUM_STAGES = 2;

  typedef struct packed {
    logic hdiv;
    logic pdiv;
  } div_sel_t;
endpackage

// File: rtl/lock_seq.sv
module lock_seq #(
  parameter int LOCK_W     = 12,
  parameter int LOCK_RESET = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ref_tick,
  input  logic              len_we,
  input  logic [LOCK_W-1:0] len_wdata,
  output logic              busy,
  output logic              pll_ok
);
  logic [LOCK_W-1:0] len_q;
  logic [LOCK_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= LOCK_W'(LOCK_RESET);
      cnt_q  <= '0;
      busy   <= 1'b0;
      pll_ok <= 1'b0;
    end else begin
      if (len_we) len_q <= len_wdata;
      if (start) begin
        cnt_q  <= len_q;
        busy   <= 1'b1;
        pll_ok <= 1'b0;
      end else if (busy && ref_tick) begin
        if (cnt_q <= LOCK_W'(1)) begin
          busy   <= 1'b0;
          pll_ok <= 1'b1;
        end else begin
          cnt_q <= cnt_q - LOCK_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/src_mux.sv
module src_mux (
  input  logic use_pll,
  input  logic ref_tick,
  input  logic pll_tick,
  output logic core_tick
);
  always_comb core_tick = use_pll ? pll_tick : ref_tick;
endmodule

// File: rtl/div_stage.sv
module div_stage (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic halve,
  input  logic in_tick,
  output logic out_tick
);
  logic skip_q;

  always_ff @(posedge clk) begin
    if (rst || restart) skip_q <= 1'b0;
    else if (in_tick && halve) skip_q <= ~skip_q;
  end

  always_comb out_tick = in_tick & (~halve | ~skip_q);
endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
  import clkswitch_pkg::*;
#(
  parameter int               CFG_W      = 20,
  parameter logic [CFG_W-1:0] CFG_RESET  = 20'h0A031,
  parameter int               LOCK_W     = 12,
  parameter int               LOCK_RESET = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              pll_tick,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              lock_we,
  input  logic [LOCK_W-1:0] lock_wdata,
  input  logic              div_we,
  input  logic [1:0]        div_wdata,
  output logic [CFG_W-1:0]  pll_cfg,
  output logic              core_en,
  output logic              hbus_en,
  output logic              pbus_en,
  output logic              lock_busy,
  output logic              on_pll
);
  div_sel_t                div_q;
  logic                    use_pll;
  logic [NUM_STAGES:0]     tick_chain;
  logic [NUM_STAGES-1:0]   halve_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_cfg <= CFG_RESET;
      div_q   <= '0;
    end else begin
      if (cfg_we) pll_cfg <= cfg_wdata;
      if (div_we) div_q   <= div_sel_t'(div_wdata);
    end
  end

  lock_seq #(.LOCK_W(LOCK_W), .LOCK_RESET(LOCK_RESET)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .start     (cfg_we),
    .ref_tick  (ref_tick),
    .len_we    (lock_we),
    .len_wdata (lock_wdata),
    .busy      (lock_busy),
    .pll_ok    (use_pll)
  );

  assign on_pll = use_pll;

  src_mux u_mux (
    .use_pll   (use_pll),
    .ref_tick  (ref_tick),
    .pll_tick  (pll_tick),
    .core_tick (tick_chain[0])
  );

  assign halve_vec = {div_q.pdiv, div_q.hdiv};

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_div
    div_stage u_stage (
      .clk      (clk),
      .rst      (rst),
      .restart  (div_we),
      .halve    (halve_vec[s]),
      .in_tick  (tick_chain[s]),
      .out_tick (tick_chain[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_en <= 1'b0;
      hbus_en <= 1'b0;
      pbus_en <= 1'b0;
    end else begin
      core_en <= tick_chain[0];
      hbus_en <= tick_chain[1];
      pbus_en <= tick_chain[2];
    end
  end
endmodule

// File: rtl/clk_switch_ctrl_chk.sv
module clk_switch_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ref_tick,
  input logic pll_tick,
  input logic cfg_we,
  input logic core_en,
  input logic hbus_en,
  input logic pbus_en,
  input logic lock_busy,
  input logic on_pll
);
  // R3
  cfg_restart_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (lock_busy && !on_pll));

  // R3
  busy_on_ref_chk: assert property (@(posedge clk) disable iff (rst)
    lock_busy |-> !on_pll);

  // R2
  ref_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !on_pll |=> (core_en == $past(ref_tick)));

  // R5
  pll_follow_chk: assert property (@(posedge clk) disable iff (rst)
    on_pll |=> (core_en == $past(pll_tick)));

  // R4
  switch_at_lock_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(on_pll) |-> $fell(lock_busy));

  // R10
  hbus_nested_chk: assert property (@(posedge clk) disable iff (rst)
    hbus_en |-> core_en);

  // R10
  pbus_nested_chk: assert property (@(posedge clk) disable iff (rst)
    pbus_en |-> hbus_en);
endmodule

bind clk_switch_ctrl clk_switch_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_tick  (ref_tick),
  .pll_tick  (pll_tick),
  .cfg_we    (cfg_we),
  .core_en   (core_en),
  .hbus_en   (hbus_en),
  .pbus_en   (pbus_en),
  .lock_busy (lock_busy),
  .on_pll    (on_pll)
);

// File: tb/tb_clk_switch_ctrl.sv
module tb_clk_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CFG_W = 12;
  localparam logic [CFG_W-1:0] CFG_RESET = 12'h0A5;
  localparam int LOCK_W = 6;
  localparam int LOCK_RESET = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0;
  logic pll_tick = 1'b0;
  logic cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic lock_we = 1'b0;
  logic [LOCK_W-1:0] lock_wdata = '0;
  logic div_we = 1'b0;
  logic [1:0] div_wdata = '0;
  logic [CFG_W-1:0] pll_cfg;
  logic core_en, hbus_en, pbus_en, lock_busy, on_pll;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  clk_switch_ctrl #(
    .CFG_W(CFG_W), .CFG_RESET(CFG_RESET),
    .LOCK_W(LOCK_W), .LOCK_RESET(LOCK_RESET)
  ) dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .pll_tick(pll_tick),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .lock_we(lock_we), .lock_wdata(lock_wdata),
    .div_we(div_we), .div_wdata(div_wdata),
    .pll_cfg(pll_cfg), .core_en(core_en), .hbus_en(hbus_en),
    .pbus_en(pbus_en), .lock_busy(lock_busy), .on_pll(on_pll)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tick sources: reference every 5th cycle, PLL every 2nd cycle
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      ref_tick = (c % 5) == 0;
      pll_tick = (c % 2) == 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [CFG_W-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_lock(input logic [LOCK_W-1:0] v);
    @(negedge clk);
    lock_we = 1'b1; lock_wdata = v;
    @(negedge clk);
    lock_we = 1'b0;
  endtask

  task automatic write_div(input logic [1:0] v);
    @(negedge clk);
    div_we = 1'b1; div_wdata = v;
    @(negedge clk);
    div_we = 1'b0;
  endtask

  // compare core_en against the expected source over n cycles, count mismatches
  task automatic follow(input string req, input bit from_pll, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      sample();
      if (core_en != (from_pll ? pll_tick : ref_tick)) bad++;
    end
    check(req, bad, 0);
  endtask

  // count reference ticks taken while busy until lock ends
  task automatic count_lock(output int n);
    n = 0;
    for (int i = 0; i < 500; i++) begin
      sample();
      if (ref_tick) n++;
      if (!lock_busy) break;
    end
  endtask

  task automatic t_reset();
    sample();
    check("R1 on_pll", on_pll, 0);
    check("R1 lock_busy", lock_busy, 0);
    check("R1 pll_cfg", pll_cfg, CFG_RESET);
    follow("R1 core from ref", 1'b0, 20);
  endtask

  task automatic t_no_write();
    follow("R2 stays on ref", 1'b0, 200);
    check("R2 on_pll", on_pll, 0);
  endtask

  task automatic t_default_write();
    int n;
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = CFG_RESET;
    sample();
    check("R3 busy after write", lock_busy, 1);
    check("R3 on_pll after write", on_pll, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    count_lock(n);
    check("R4 lock ticks N=4", n, LOCK_RESET);
    check("R4 on_pll at end", on_pll, 1);
    follow("R5 core from pll", 1'b1, 30);
  endtask

  task automatic t_fallback();
    int n;
    write_cfg(12'h3C1);
    check("R3 pll_cfg updated", pll_cfg, 12'h3C1);
    follow("R3 back on ref", 1'b0, 8);
    count_lock(n);
    check("R5 on_pll after relock", on_pll, 1);
  endtask

  task automatic t_restart();
    int n = 0;
    write_cfg(12'h111);
    while (n < 2) begin
      sample();
      if (ref_tick) n++;
    end
    write_cfg(12'h222);
    count_lock(n);
    check("R6 full restart", n, LOCK_RESET);
  endtask

  task automatic t_lock_mid();
    int n = 0;
    write_cfg(12'h333);
    write_lock(6'd7);
    count_lock(n);
    check("R7 running count kept", n, LOCK_RESET);
    write_cfg(12'h334);
    count_lock(n);
    check("R7 new length used", n, 7);
    write_lock(6'd0);
    write_cfg(12'h335);
    count_lock(n);
    check("R4 length 0", n, 1);
    write_lock(6'd1);
    write_cfg(12'h336);
    count_lock(n);
    check("R4 length 1", n, 1);
  endtask

  task automatic t_div(input logic [1:0] d, input int exp_h, input int exp_p);
    int nc = 0, nh = 0, np = 0, bad = 0;
    write_div(d);
    for (int i = 0; i < 40; i++) begin
      sample();
      nc += core_en;
      nh += hbus_en;
      np += pbus_en;
      if ((hbus_en && !core_en) || (pbus_en && !hbus_en)) bad++;
    end
    check("R10 enables nested", bad, 0);
    check("R5 core count", nc, 20);
    check("R8 hbus count", nh, exp_h);
    check("R9 pbus count", np, exp_p);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_no_write();
    t_default_write();
    t_fallback();
    t_restart();
    t_lock_mid();
    t_div(2'b00, 20, 20);
    t_div(2'b10, 10, 10);
    t_div(2'b01, 20, 10);
    t_div(2'b11, 10, 5);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule